// File: doc/BRIEF.md
# Two-Channel Successive-Approximation Conversion Controller

This block is the digital half of a two-input successive-approximation converter. It sits on a small controller's register bus and exposes four byte registers: control, clock divider, result high and result low. A conversion begins when software writes the control register with the start bit and the enable bit both set. The block latches the selected channel and holds the sample phase for a fixed number of conversion clocks. It then runs a binary search, most significant bit first, one bit per conversion clock.

On each search step the block drives a trial code to an external resistor-ladder DAC. It reads back one comparator bit, which is 1 when the held input is at or above the DAC level. At the end it loads both result registers and sets an end-of-conversion flag. An interrupt request is produced from that flag, qualified by an enable bit that lives in the system interrupt controller. The sample-and-hold, the DAC and the comparator are outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Control bit 0 selects input 0 or 1 (output `ain_sel`). The value written together with the start bit is latched for the whole conversion. Changing bit 0 while a conversion runs does not change the channel used or the result.
- R2: With a comparator that returns 1 exactly when the input code is greater than or equal to `dac_code`, the result is the largest 10-bit code not above the input. For an ideal input code this is the input code itself.
- R3: Address 2 reads result bits 9..2. Address 3 reads result bits 1..0 in its bits 1..0, and its upper bits read 0.
- R4: At address 0, bit 5 is enable, bit 3 is start and bit 4 is end-of-conversion. Start reads 1 while a conversion runs. The block clears start in the same cycle that it writes the result.
- R5: A write to address 0 starts a conversion only when the same write sets both bit 3 and bit 5. A start with enable 0 leaves start at 0 and produces no result.
- R6: Writing 0 to bit 4 clears end-of-conversion. Writing 1 to bit 4 leaves the flag unchanged.
- R7: `irq` is high exactly when end-of-conversion is set and `irq_en_in` is high.
- R8: Address 1 holds the divider value N. The conversion clock period is 2*(N+1) system cycles. End-of-conversion becomes visible exactly 14*2*(N+1) cycles after the clock edge that accepts the start write: 4 sample clocks and 10 search clocks.
- R9: Both result registers change only in the cycle end-of-conversion is set. They keep their value during a conversion and after an aborted one.
- R10: Writing enable 0 during a conversion aborts it. Start clears, no result is written, end-of-conversion stays clear, and a later start works normally.
- R11: After reset all four registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 divider, 2 result high, 3 result low) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_en_in | input | 1 | Converter interrupt enable from the interrupt controller |
| irq | output | 1 | Gated end-of-conversion interrupt request |
| ain_sel | output | 1 | Analog input multiplexer select |
| sample_hold | output | 1 | High during the sample phase |
| dac_code | output | 10 | Trial code to the DAC |
| cmp_in | input | 1 | Comparator result, 1 when input is at or above the DAC level |

## Verification
The search is driven with input codes at both range ends (0 and 1023), with the neighbours 511 and 512 across the top-bit boundary, and with alternating-bit patterns 0x155 and 0x2AA. The two channels always carry different codes, so a wrong channel, an inverted comparator sense or a bit decided out of order gives a distinct wrong result. Several divider values, including the maximum, separate a correct conversion clock period from an off-by-one in the prescaler or in the phase lengths. Directed cases cover a channel change during a conversion, a start without enable, an abort, and clearing the flag with and without the interrupt enable.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_SEARCH = 2'd2
   } phase_e;

   localparam logic [1:0] REG_CTRL   = 2'd0;
   localparam logic [1:0] REG_CLKDIV = 2'd1;
   localparam logic [1:0] REG_RES_HI = 2'd2;
   localparam logic [1:0] REG_RES_LO = 2'd3;

   localparam int CTL_CH_BIT  = 0;
   localparam int CTL_GO_BIT  = 3;
   localparam int CTL_EOC_BIT = 4;
   localparam int CTL_EN_BIT  = 5;

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // one tick every 2*(div+1) cycles: count 0 .. 2*div+1
   assign limit = {div, 1'b1};
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // shortest period is two cycles, so ticks never touch
   assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_adc_pkg::*;
#(
   parameter int RES_W        = 10,
   parameter int SAMPLE_TICKS = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   go,
   input  logic   abort,
   input  logic   tick,
   output phase_e phase,
   output logic   busy,
   output logic   load,
   output logic   step,
   output logic   done
);
   localparam int BIT_W = $clog2(RES_W);

   phase_e           phase_q;
   logic [BIT_W-1:0] bcnt_q;

   assign step = (phase_q == PH_SEARCH) && tick && !abort;
   assign done = step && (bcnt_q == '0);

   generate
      if (SAMPLE_TICKS > 0) begin : g_sample
         localparam int SC_W = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
         logic [SC_W-1:0] scnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               scnt_q <= '0;
            else if (phase_q != PH_SAMPLE)
               scnt_q <= '0;
            else if (tick)
               scnt_q <= scnt_q + 1'b1;
         end

         assign load = (phase_q == PH_SAMPLE) && tick && !abort &&
                       (scnt_q == SC_W'(SAMPLE_TICKS - 1));
      end else begin : g_direct
         assign load = go;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
      end else begin
         case (phase_q)
            PH_IDLE:   if (go) phase_q <= (SAMPLE_TICKS > 0) ? PH_SAMPLE : PH_SEARCH;
            PH_SAMPLE: if (abort) phase_q <= PH_IDLE;
                       else if (load) phase_q <= PH_SEARCH;
            PH_SEARCH: if (abort || done) phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bcnt_q <= '0;
      else if (load)
         bcnt_q <= BIT_W'(RES_W - 1);
      else if (step)
         bcnt_q <= bcnt_q - 1'b1;
   end

   assign phase = phase_q;
   assign busy  = (phase_q != PH_IDLE);

   // the sequencer accepts a start only from idle
   assert_go_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && phase_q == PH_IDLE && SAMPLE_TICKS > 0) |=> (phase_q == PH_SAMPLE));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             cmp,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result_nxt
);
   logic [RES_W-1:0] res_q;
   logic [RES_W-1:0] mask_q;
   logic [RES_W-1:0] res_d;

   // the bit under trial keeps the comparator verdict, others hold
   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      assign res_d[i] = load ? 1'b0 : ((step && mask_q[i]) ? cmp : res_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         mask_q <= '0;
      end else begin
         res_q <= res_d;
         if (load)
            mask_q <= {1'b1, {(RES_W-1){1'b0}}};
         else if (step)
            mask_q <= mask_q >> 1;
      end
   end

   assign trial      = res_q | mask_q;
   assign result_nxt = res_d;

   // at most one bit is on trial at any time
   assert_single_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q));

   // a failing comparison drops the trial bit from the code
   assert_reject_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cmp && !load) |=> ((res_q & $past(mask_q)) == '0));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
   import sar_adc_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int RES_W        = 10,
   parameter int HI_W         = 8,
   parameter int DIV_W        = 8,
   parameter int SAMPLE_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              irq_en_in,
   output logic              irq,
   output logic              ain_sel,
   output logic              sample_hold,
   output logic [RES_W-1:0]  dac_code,
   input  logic              cmp_in
);
   localparam int LO_W = RES_W - HI_W;

   initial begin
      assert (DATA_W >= CTL_EN_BIT + 1) else $error("data width too small for control bits");
      assert (HI_W >= 1 && HI_W <= DATA_W) else $error("high result field does not fit");
      assert (LO_W >= 1 && LO_W <= DATA_W) else $error("low result field does not fit");
      assert (DIV_W >= 1 && DIV_W <= DATA_W) else $error("divider width does not fit");
      assert (RES_W >= 2) else $error("resolution too small");
      assert (SAMPLE_TICKS >= 0) else $error("negative sample length");
   end

   logic              en_q, go_q, eoc_q, ch_q, ch_lat_q;
   logic [DIV_W-1:0]  div_q;
   logic [HI_W-1:0]   dhi_q;
   logic [LO_W-1:0]   dlo_q;

   logic              wr_ctrl, wr_div, go_req, abort;
   logic              tick, busy, load, step, done;
   phase_e            phase;
   logic [RES_W-1:0]  res_nxt;
   logic              wdata_unused;

   assign wdata_unused = ^bus_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
   assign wr_div  = bus_wr && (bus_addr == REG_CLKDIV);
   assign go_req  = wr_ctrl && bus_wdata[CTL_GO_BIT] && bus_wdata[CTL_EN_BIT] && !busy;
   assign abort   = wr_ctrl && !bus_wdata[CTL_EN_BIT] && busy;

   sar_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
   );

   sar_seq #(.RES_W(RES_W), .SAMPLE_TICKS(SAMPLE_TICKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go_req), .abort(abort), .tick(tick),
      .phase(phase), .busy(busy), .load(load), .step(step), .done(done)
   );

   sar_search #(.RES_W(RES_W)) u_sar (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .cmp(cmp_in),
      .trial(dac_code), .result_nxt(res_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         ch_q     <= 1'b0;
         ch_lat_q <= 1'b0;
         go_q     <= 1'b0;
         eoc_q    <= 1'b0;
         div_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q <= bus_wdata[CTL_EN_BIT];
            ch_q <= bus_wdata[CTL_CH_BIT];
         end
         if (go_req)
            ch_lat_q <= bus_wdata[CTL_CH_BIT];
         if (done || abort)
            go_q <= 1'b0;
         else if (go_req)
            go_q <= 1'b1;
         if (done)
            eoc_q <= 1'b1;
         else if (wr_ctrl && !bus_wdata[CTL_EOC_BIT])
            eoc_q <= 1'b0;
         if (wr_div)
            div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   // both halves of the result load on one edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dhi_q <= '0;
         dlo_q <= '0;
      end else if (done) begin
         dhi_q <= res_nxt[RES_W-1 -: HI_W];
         dlo_q <= res_nxt[LO_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: begin
            bus_rdata[CTL_CH_BIT]  = ch_q;
            bus_rdata[CTL_GO_BIT]  = go_q;
            bus_rdata[CTL_EOC_BIT] = eoc_q;
            bus_rdata[CTL_EN_BIT]  = en_q;
         end
         REG_CLKDIV: bus_rdata = DATA_W'(div_q);
         REG_RES_HI: bus_rdata = DATA_W'(dhi_q);
         default:    bus_rdata = DATA_W'(dlo_q);
      endcase
   end

   assign ain_sel     = busy ? ch_lat_q : ch_q;
   assign sample_hold = (phase == PH_SAMPLE);
   assign irq         = eoc_q && irq_en_in;

   assert_chan_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ain_sel));

   assert_go_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |-> en_q);

   assert_eoc_clears_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_q) |-> !go_q);

   assert_result_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({dhi_q, dlo_q}) |-> $past(done));

   assert_abort_no_eoc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy);

endmodule

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq_en_in = 1'b1;
   logic       irq, ain_sel, sample_hold, cmp_in;
   logic [9:0] dac_code;
   logic [9:0] vin0 = 10'd0;
   logic [9:0] vin1 = 10'd0;

   int  total = 0;
   int  bad = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   // ideal comparator against the stored input code
   assign cmp_in = ((ain_sel ? vin1 : vin0) >= dac_code);

   sar_adc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en_in(irq_en_in),
      .irq(irq), .ain_sel(ain_sel), .sample_hold(sample_hold),
      .dac_code(dac_code), .cmp_in(cmp_in)
   );

   // channel, input0, input1, divider
   localparam int VEC [10][4] = '{
      '{0,    0, 1023, 0}, '{1,    0, 1023, 0}, '{0, 1023,    0, 1},
      '{0,  512,  511, 0}, '{1,  512,  511, 2}, '{0,  511,    0, 0},
      '{1, 'h155, 'h2AA, 0}, '{0, 'h2AA, 'h155, 3}, '{1,    1,    2, 0},
      '{0,    3,    5, 1}
   };

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   // call right after wr(): counts edges from the accepting edge
   task automatic wait_eoc(input int limit, output int cyc);
      cyc = -1;
      bus_addr = 2'd0;
      for (int k = 1; k <= limit; k++) begin
         @(posedge clk);
         #1;
         if (bus_rdata[4]) begin
            cyc = k;
            break;
         end
      end
   endtask

   task automatic read_result(output int r);
      int h, l;
      rd(2'd2, h);
      rd(2'd3, l);
      r = (h << 2) | l;
   endtask

   initial begin
      #750000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v, cyc, r, prev;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check($sformatf("R11 reg %0d after reset", a), v, 0);
      end
      check("R11 irq after reset", int'(irq), 0);

      // vector table
      for (int i = 0; i < 10; i++) begin
         int ch, dv, ex;
         ch = VEC[i][0]; dv = VEC[i][3];
         vin0 = 10'(VEC[i][1]); vin1 = 10'(VEC[i][2]);
         ex = ch ? VEC[i][2] : VEC[i][1];
         wr(2'd1, 8'(dv));
         wr(2'd0, 8'h28 | 8'(ch));
         wait_eoc(20000, cyc);
         check($sformatf("R8 vec %0d eoc latency", i), cyc, 28 * (dv + 1));
         rd(2'd2, v);
         check($sformatf("R2 R3 vec %0d high reg", i), v, ex >> 2);
         rd(2'd3, v);
         check($sformatf("R3 vec %0d low reg", i), v, ex & 3);
         rd(2'd0, v);
         check($sformatf("R4 vec %0d ctrl after eoc", i), v, 'h30 | ch);
         check($sformatf("R7 vec %0d irq raised", i), int'(irq), 1);
         wr(2'd0, 8'h20 | 8'(ch));
         rd(2'd0, v);
         check($sformatf("R6 vec %0d eoc cleared", i), v, 'h20 | ch);
         check($sformatf("R7 vec %0d irq dropped", i), int'(irq), 0);
      end

      // R5 start without enable
      read_result(prev);
      wr(2'd0, 8'h08);
      rd(2'd0, v);
      check("R5 ctrl after start without enable", v, 0);
      wait_eoc(200, cyc);
      check("R5 no eoc without enable", cyc, -1);
      read_result(r);
      check("R5 result untouched", r, prev);

      // R10 abort mid-search, then restart
      vin0 = 10'd777;
      wr(2'd1, 8'd3);
      wr(2'd0, 8'h28);
      repeat (60) @(posedge clk);
      wr(2'd0, 8'h00);
      rd(2'd0, v);
      check("R10 start cleared by abort", v, 0);
      wait_eoc(300, cyc);
      check("R10 no eoc after abort", cyc, -1);
      read_result(r);
      check("R9 R10 result kept after abort", r, prev);
      wr(2'd0, 8'h28);
      wait_eoc(20000, cyc);
      read_result(r);
      check("R10 restart result", r, 777);
      wr(2'd0, 8'h20);

      // R1 channel change during conversion
      vin0 = 10'd100; vin1 = 10'd900;
      wr(2'd1, 8'd1);
      wr(2'd0, 8'h28);
      repeat (20) @(posedge clk);
      rd(2'd2, v);
      check("R9 high reg held mid conversion", v, 777 >> 2);
      wr(2'd0, 8'h21);
      wait_eoc(20000, cyc);
      read_result(r);
      check("R1 latched channel result", r, 100);
      rd(2'd0, v);
      check("R1 ctrl shows new channel", v, 'h31);
      wr(2'd0, 8'h21);

      // R7 gating and R6 write-one keeps flag
      irq_en_in = 1'b0;
      vin1 = 10'd300;
      wr(2'd0, 8'h29);
      wait_eoc(20000, cyc);
      #1;
      check("R7 irq masked", int'(irq), 0);
      irq_en_in = 1'b1;
      #1;
      check("R7 irq unmasked", int'(irq), 1);
      wr(2'd0, 8'h31);
      rd(2'd0, v);
      check("R6 write one keeps eoc", v, 'h31);
      read_result(r);
      check("R2 channel 1 result", r, 300);
      wr(2'd0, 8'h21);
      rd(2'd0, v);
      check("R6 write zero clears eoc", v, 'h21);

      // R8 maximum divider
      vin0 = 10'd1000;
      wr(2'd1, 8'd255);
      rd(2'd1, v);
      check("R8 divider readback", v, 255);
      wr(2'd0, 8'h28);
      wait_eoc(20000, cyc);
      check("R8 latency at max divider", cyc, 28 * 256);
      read_result(r);
      check("R2 result at max divider", r, 1000);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule